// File: doc/BRIEF.md
# Indirect Command-Word Register Window

This block puts the whole internal register set of a serial-bus controller behind one 64-bit command/response word. A host writes a command word with its top bit set. The word carries a read/write flag, an operation code, a 3-bit internal-register index and a data field. The block takes the command and performs the internal access a fixed number of cycles later. It then clears the top bit. The host polls that bit to learn when the access has finished.

For a read, the selected 8-bit internal value comes back in the low bits of the same word. For a write, the data field goes into the selected internal register. The configuration registers drive the serial engine directly: own address, extended address, control byte, transmit byte, and the two clock divider fields. A reset index gives the engine a one-cycle reset pulse. The engine feeds back a state code and the last received byte, and these can be read through the window.

Only operation code 6 reaches the internal registers. A command with any other code completes on the same schedule but has no effect. If the host writes a new command while one is still in flight, the new command is dropped and a sticky error flag is raised.

Top module: `regwin_top`

## Requirements
- R1: A host write whose bit 63 is 1, made while no command is pending, is accepted. From the next cycle `host_rdata` shows bit 63 as 1, with bits 62:0 as written.
- R2: Bit 63 of `host_rdata` stays 1 for exactly LAT cycles after acceptance (default 3), then returns to 0 by itself.
- R3: A host write whose bit 63 is 0 has no effect: `host_rdata` is unchanged and no command starts.
- R4: A host write made while bit 63 of `host_rdata` is 1 is ignored. The pending command completes with its own fields.
- R5: The ignored write of R4 sets `cmd_err`. The flag stays set until reset.
- R6: With opcode 6 (bits 60:57) and bit 56 = 0, a write goes to an internal register selected by bits 34:32. Index 0 loads `own_addr`, index 1 loads `tx_byte`, index 2 loads `ctrl_reg` and index 4 loads `ext_addr`, each from bits 7:0.
- R7: An opcode-6 write to index 3 loads `m_div` from data bits 6:3 and `n_div` from data bits 2:0.
- R8: An opcode-6 read (bit 56 = 1) returns the selected value in bits 7:0 with bits 31:8 cleared. The sources are: index 0 own address, 1 `rx_byte`, 2 control, 3 `status_code`, 4 extended address, and 5 to 7 zero. All other bits echo the command.
- R9: An opcode-6 write to index 7 raises `eng_rst` for exactly one cycle, in the cycle in which bit 63 clears. Writes to index 5 or 6 change nothing.
- R10: A command with an opcode other than 6 completes per R2, changes no internal register, and echoes bits 62:0 unchanged, including the data field.
- R11: After reset, `host_rdata`, `cmd_err`, `eng_rst` and all configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| status_code | input | 8 | Current state code from the serial engine |
| rx_byte | input | 8 | Last byte received by the serial engine |
| host_rdata | output | 64 | Command/response word; bit 63 is the pending flag |
| cmd_err | output | 1 | Sticky flag: a command arrived while busy |
| own_addr | output | 8 | Own slave address register |
| ext_addr | output | 8 | Extended slave address register |
| ctrl_reg | output | 8 | Control register |
| tx_byte | output | 8 | Transmit data register |
| m_div | output | 4 | Clock divider M |
| n_div | output | 3 | Clock divider N |
| eng_rst | output | 1 | One-cycle reset pulse to the serial engine |

## Verification
A stuck or miscounted sequencer shows at the ports as soon as the command is accepted. Bit 63 either clears too early or too late, or never clears at all, and the bench checks this against an exact LAT-cycle count on every command. A wrong index decode, or a wrong read multiplexer, shows on the next read of that index as a wrong low byte or unexpected high data bits. A lost or misplaced write shows on the configuration outputs as soon as bit 63 falls. A broken busy guard shows within one command: the pending word is overwritten, or `cmd_err` fails to set.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int CMD_W   = 64;
  localparam int VLD_BIT = 63;
  localparam int RD_BIT  = 56;
  localparam int OP_LO   = 57;
  localparam int OP_W    = 4;
  localparam int IDX_LO  = 32;
  localparam int IDX_W   = 3;
  localparam int DFLD_W  = 32;
  localparam int MDIV_W  = 4;
  localparam int NDIV_W  = 3;
  localparam logic [OP_W-1:0] OP_INTREG = 4'd6;

  typedef enum logic [IDX_W-1:0] {
    IX_OWN  = 3'd0,
    IX_DATA = 3'd1,
    IX_CTRL = 3'd2,
    IX_CLK  = 3'd3,
    IX_EXT  = 3'd4,
    IX_SP5  = 3'd5,
    IX_SP6  = 3'd6,
    IX_RST  = 3'd7
  } reg_ix_e;

  typedef struct packed {
    logic            rd;
    logic [OP_W-1:0] op;
    reg_ix_e         idx;
    logic [7:0]      data;
  } cmd_fields_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
(
  input  logic [CMD_W-2:0] word,
  output cmd_fields_t      fld,
  output logic             intreg_hit
);
  always_comb begin
    fld.rd     = word[RD_BIT];
    fld.op     = word[OP_LO +: OP_W];
    fld.idx    = reg_ix_e'(word[IDX_LO +: IDX_W]);
    fld.data   = word[7:0];
    intreg_hit = (fld.op == OP_INTREG);
  end
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic busy,
  output logic done
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
  import regwin_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_ix_e           idx,
  input  logic [7:0]        wdata,
  input  logic [DW-1:0]     status_code,
  input  logic [DW-1:0]     rx_byte,
  output logic [DW-1:0]     rd_value,
  output logic [DW-1:0]     own_addr,
  output logic [DW-1:0]     ext_addr,
  output logic [DW-1:0]     ctrl_reg,
  output logic [DW-1:0]     tx_byte,
  output logic [MDIV_W-1:0] m_div,
  output logic [NDIV_W-1:0] n_div,
  output logic              eng_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= '0;
      ext_addr <= '0;
      ctrl_reg <= '0;
      tx_byte  <= '0;
      m_div    <= '0;
      n_div    <= '0;
      eng_rst  <= 1'b0;
    end else begin
      eng_rst <= 1'b0;
      if (wr_en) begin
        unique case (idx)
          IX_OWN:  own_addr <= DW'(wdata);
          IX_DATA: tx_byte  <= DW'(wdata);
          IX_CTRL: ctrl_reg <= DW'(wdata);
          IX_CLK: begin
            m_div <= wdata[NDIV_W +: MDIV_W];
            n_div <= wdata[NDIV_W-1:0];
          end
          IX_EXT:  ext_addr <= DW'(wdata);
          IX_RST:  eng_rst  <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (idx)
      IX_OWN:  rd_value = own_addr;
      IX_DATA: rd_value = rx_byte;
      IX_CTRL: rd_value = ctrl_reg;
      IX_CLK:  rd_value = status_code;
      IX_EXT:  rd_value = ext_addr;
      default: rd_value = '0;
    endcase
  end
endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [63:0]       host_wdata,
  input  logic [DW-1:0]     status_code,
  input  logic [DW-1:0]     rx_byte,
  output logic [63:0]       host_rdata,
  output logic              cmd_err,
  output logic [DW-1:0]     own_addr,
  output logic [DW-1:0]     ext_addr,
  output logic [DW-1:0]     ctrl_reg,
  output logic [DW-1:0]     tx_byte,
  output logic [MDIV_W-1:0] m_div,
  output logic [NDIV_W-1:0] n_div,
  output logic              eng_rst
);
  logic [CMD_W-2:0] cmd_q;
  logic             busy, done, accept, hit, wr_en;
  cmd_fields_t      fld;
  logic [DW-1:0]    rd_value;

  assign accept = host_wr && host_wdata[VLD_BIT] && !busy;
  assign wr_en  = done && hit && !fld.rd;

  regwin_decode u_dec (
    .word       (cmd_q),
    .fld        (fld),
    .intreg_hit (hit)
  );

  regwin_seq #(.LAT(LAT)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  regwin_bank #(.DW(DW)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .idx         (fld.idx),
    .wdata       (fld.data),
    .status_code (status_code),
    .rx_byte     (rx_byte),
    .rd_value    (rd_value),
    .own_addr    (own_addr),
    .ext_addr    (ext_addr),
    .ctrl_reg    (ctrl_reg),
    .tx_byte     (tx_byte),
    .m_div       (m_div),
    .n_div       (n_div),
    .eng_rst     (eng_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      cmd_err <= 1'b0;
    end else begin
      if (host_wr && busy)
        cmd_err <= 1'b1;
      if (accept)
        cmd_q <= host_wdata[CMD_W-2:0];
      else if (done && hit && fld.rd)
        cmd_q[DFLD_W-1:0] <= DFLD_W'(rd_value);
    end
  end

  assign host_rdata = {busy, cmd_q};
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic [63:0]   host_rdata,
  input logic          cmd_err,
  input logic          eng_rst,
  input logic [DW-1:0] own_addr,
  input logic [DW-1:0] ext_addr,
  input logic [DW-1:0] ctrl_reg,
  input logic [DW-1:0] tx_byte,
  input logic [3:0]    m_div,
  input logic [2:0]    n_div
);
  localparam int VW = $clog2(LAT + 2) + 1;
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst)                vcnt <= '0;
    else if (host_rdata[63]) vcnt <= vcnt + 1'b1;
    else                    vcnt <= '0;
  end

  a_r1_start_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rdata[63]) |-> $past(host_wr));

  a_r2_valid_bounded: assert property (@(posedge clk) disable iff (rst)
    host_rdata[63] |-> (vcnt < VW'(LAT)));

  a_r5_busy_write_flags: assert property (@(posedge clk) disable iff (rst)
    (host_rdata[63] && host_wr) |=> cmd_err);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);

  a_r9_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
    eng_rst |=> !eng_rst);

  a_r9_rst_at_completion: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_rst) |-> $fell(host_rdata[63]));

  a_r6_idle_regs_stable: assert property (@(posedge clk) disable iff (rst)
    !host_rdata[63] |=> $stable({own_addr, ext_addr, ctrl_reg, tx_byte, m_div, n_div}));
endmodule

bind regwin_top regwin_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .cmd_err    (cmd_err),
  .eng_rst    (eng_rst),
  .own_addr   (own_addr),
  .ext_addr   (ext_addr),
  .ctrl_reg   (ctrl_reg),
  .tx_byte    (tx_byte),
  .m_div      (m_div),
  .n_div      (n_div)
);

// File: tb/test_regwin_top.sv
`timescale 1ns/1ps
module test_regwin_top;
  localparam int LAT = 3;
  logic clk = 1'b0, rst = 1'b1, host_wr = 1'b0;
  logic [63:0] host_wdata = '0, host_rdata;
  logic [7:0]  status_code = '0, rx_byte = '0;
  logic        cmd_err, eng_rst;
  logic [7:0]  own_addr, ext_addr, ctrl_reg, tx_byte;
  logic [3:0]  m_div;
  logic [2:0]  n_div;
  int errors = 0, checks = 0;
  logic [7:0] m_own = 0, m_ext = 0, m_ctrl = 0, m_tx = 0;
  logic [3:0] m_m = 0;
  logic [2:0] m_n = 0;

  always #2.5 clk = ~clk;

  regwin_top #(.DW(8), .LAT(LAT)) i_regwin_top (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .status_code(status_code), .rx_byte(rx_byte), .host_rdata(host_rdata),
    .cmd_err(cmd_err), .own_addr(own_addr), .ext_addr(ext_addr),
    .ctrl_reg(ctrl_reg), .tx_byte(tx_byte), .m_div(m_div), .n_div(n_div),
    .eng_rst(eng_rst));

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mkcmd(input logic rd, input logic [3:0] op,
                                        input logic [2:0] idx, input logic [7:0] d);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[63] = 1'b1; w[56] = rd; w[60:57] = op; w[34:32] = idx; w[31:0] = {$urandom} & 32'hFFFF_FF00 | {24'd0, d};
    return w;
  endfunction

  function automatic logic [7:0] rd_model(input logic [2:0] idx);
    case (idx)
      3'd0: return m_own;
      3'd1: return rx_byte;
      3'd2: return m_ctrl;
      3'd3: return status_code;
      3'd4: return m_ext;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [63:0] exp_word(input logic [63:0] w);
    logic [63:0] e;
    e = w; e[63] = 1'b0;
    if (w[56] && w[60:57] == 4'd6) e[31:0] = {24'd0, rd_model(w[34:32])};
    return e;
  endfunction

  task automatic model_write(input logic [63:0] w);
    if (!w[56] && w[60:57] == 4'd6)
      case (w[34:32])
        3'd0: m_own = w[7:0];
        3'd1: m_tx = w[7:0];
        3'd2: m_ctrl = w[7:0];
        3'd3: begin m_m = w[6:3]; m_n = w[2:0]; end
        3'd4: m_ext = w[7:0];
        default: ;
      endcase
  endtask

  task automatic issue(input logic [63:0] w, output int n);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
    n = 0;
    while (host_rdata[63] && n < 20) begin n++; @(negedge clk); end
  endtask

  task automatic chk_regs(input string rq);
    chk(rq, {own_addr, ext_addr, ctrl_reg, tx_byte, m_div, n_div},
            {m_own, m_ext, m_ctrl, m_tx, m_m, m_n});
  endtask

  task automatic run_cmd(input logic [63:0] w, input string rq);
    int n;
    logic [63:0] e;
    e = exp_word(w);
    issue(w, n);
    model_write(w);
    chk({rq, " R2 latency"}, 64'(n), 64'(LAT));
    chk({rq, " word"}, host_rdata, e);
    chk({rq, " R9 pulse"}, 64'(eng_rst),
        64'(!w[56] && w[60:57] == 4'd6 && w[34:32] == 3'd7));
    chk_regs({rq, " regs"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] w, w2, prev;
    int n;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata", host_rdata, 64'd0);
    chk("R11 err/rst", {cmd_err, eng_rst}, 2'b00);
    chk_regs("R11 regs");

    // R1 acceptance and echo
    w = mkcmd(1'b0, 4'd6, 3'd2, 8'hA5);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
    chk("R1 pending word", host_rdata, w);
    while (host_rdata[63]) @(negedge clk);
    model_write(w);
    chk("R6 ctrl write", 64'(ctrl_reg), 64'hA5);

    // R6 / R8 / R7 directed
    run_cmd(mkcmd(1'b0, 4'd6, 3'd0, 8'h3C), "R6 own");
    run_cmd(mkcmd(1'b0, 4'd6, 3'd4, 8'hC3), "R6 ext");
    run_cmd(mkcmd(1'b0, 4'd6, 3'd1, 8'h5A), "R6 tx");
    run_cmd(mkcmd(1'b0, 4'd6, 3'd3, 8'b0_1011_110), "R7 clk");
    chk("R7 m/n", {m_div, n_div}, {4'b1011, 3'b110});
    status_code = 8'hF8; rx_byte = 8'h77;
    run_cmd(mkcmd(1'b1, 4'd6, 3'd3, 8'h00), "R8 status");
    run_cmd(mkcmd(1'b1, 4'd6, 3'd1, 8'h00), "R8 rxbyte");
    run_cmd(mkcmd(1'b1, 4'd6, 3'd0, 8'h11), "R8 own");
    run_cmd(mkcmd(1'b1, 4'd6, 3'd6, 8'h22), "R8 idx6");

    // R9 reset pulse then drop
    run_cmd(mkcmd(1'b0, 4'd6, 3'd7, 8'hFF), "R9 rst");
    @(negedge clk);
    chk("R9 pulse one cycle", 64'(eng_rst), 64'd0);
    run_cmd(mkcmd(1'b0, 4'd6, 3'd5, 8'h99), "R9 idx5");

    // R10 other opcode
    run_cmd(mkcmd(1'b0, 4'd2, 3'd2, 8'h01), "R10 write op2");
    run_cmd(mkcmd(1'b1, 4'd0, 3'd3, 8'h44), "R10 read op0");

    // R3 write without valid bit
    prev = host_rdata;
    w = mkcmd(1'b0, 4'd6, 3'd0, 8'hEE); w[63] = 1'b0;
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
    chk("R3 no start", host_rdata, prev);
    repeat (LAT + 1) @(negedge clk);
    chk_regs("R3 no write");
    chk("R3 no err", 64'(cmd_err), 64'd0);

    // R4 / R5 write while busy
    w  = mkcmd(1'b0, 4'd6, 3'd4, 8'h12);
    w2 = mkcmd(1'b0, 4'd6, 3'd0, 8'h34);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wdata = w2;
    @(negedge clk); host_wr = 1'b0;
    n = 0;
    while (host_rdata[63] && n < 20) begin n++; @(negedge clk); end
    model_write(w);
    chk("R4 first cmd kept", host_rdata, exp_word(w));
    chk_regs("R4 second ignored");
    chk("R5 err set", 64'(cmd_err), 64'd1);
    repeat (5) @(negedge clk);
    chk("R5 err sticky", 64'(cmd_err), 64'd1);

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [3:0] op;
      op = ($urandom % 4 == 0) ? 4'($urandom) : 4'd6;
      status_code = 8'($urandom); rx_byte = 8'($urandom);
      run_cmd(mkcmd(1'($urandom), op, 3'($urandom), 8'($urandom)), "R6/R8/R10 random");
    end

    // R11 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_own = 0; m_ext = 0; m_ctrl = 0; m_tx = 0; m_m = 0; m_n = 0;
    @(negedge clk);
    chk("R11 rdata after reset", host_rdata, 64'd0);
    chk("R11 err cleared", 64'(cmd_err), 64'd0);
    chk_regs("R11 regs after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule